// File: doc/BRIEF.md
# Oscillator Setting Calculator

This block turns a requested clock frequency into the three settings a programmable oscillator needs: a power-of-two prescaler exponent, an absolute offset value, and a left-justified DAC word. The request is an unsigned fixed-point number in units of 10 kHz with `FRAC_W` fractional bits (default 4, so one input step is 625 Hz). The block also takes the factory offset value that software has read from the oscillator. A one-cycle `start_i` launches a run. The block first walks the exponent upward until the scaled master frequency falls inside the legal window. It then scans the relative offset ranges one per cycle and keeps the range whose centre lies nearest the master frequency.

When the run ends, `done_o` pulses and all result fields are valid together. The fields are the exponent, the offset, the DAC word, the output frequency the settings will actually give, and the signed difference from the request. If no setting exists, `err_o` is raised with `done_o` and every result field is zero. The rounding of the master frequency to a whole 10 kHz step is chosen by a parameter: round half up (the default) or truncate.

Top module: `osc_calc_top`

## Requirements
- R1: While reset is low and after it is released, `done_o`, `err_o` and `busy_o` are 0 and every result field is 0 until the first run completes.
- R2: The exponent is the smallest x in 0..8 for which desired·2^x lies in the master window of 6600..13300 (10 kHz units, both ends included, compared at full fixed-point precision).
- R3: If no x in 0..8 gives a legal master frequency, `done_o` rises 9 cycles after the start edge with `err_o` = 1, and all result fields are 0.
- R4: The master frequency is rounded half up to a whole step: m = floor(desired·2^x/16 + 1/2). Relative range k (−6..+6) covers minimum 9216 + 512·k up to that minimum + 1023. Among the ranges that cover m, the one with the centre (minimum + 511.5) closest to m is chosen.
- R5: The DAC word is (m − minimum of the chosen range) shifted left by 6 bits into 16 bits. Code 272 gives 4400h.
- R6: The offset output is the 5-bit factory offset plus k. If that sum is below 0 or above 31, the run ends with `err_o` = 1 and zero fields.
- R7: `expected_o` = floor(m·16 / 2^x) in input units. `freq_err_o` = `expected_o` − desired, as a signed value.
- R8: On success `done_o` rises x + 14 cycles after the start edge. `busy_o` is 1 from the cycle after an accepted start until the cycle `done_o` rises, when it is 0.
- R9: `done_o` is high for exactly one cycle. The result fields keep their values until the next `done_o`.
- R10: A `start_i` pulse while `busy_o` is 1 is ignored: the running result is unchanged and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a run (sampled when idle) |
| desired_i | input | FREQ_W | Requested frequency, 10 kHz units with FRAC_W fraction bits |
| factory_os_i | input | OS_W | Factory offset value |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No valid setting exists (valid with done) |
| prescale_exp_o | output | XW | Prescaler exponent x |
| offset_o | output | OS_W | Absolute offset value |
| dac_word_o | output | WORD_W | Left-justified DAC register word |
| expected_o | output | EW | Output frequency achieved, input units |
| freq_err_o | output | ERR_W | Signed achieved minus requested, input units |

## Verification
The result of a run is due a number of cycles after the start edge that depends on the run. A successful run with exponent x finishes x + 14 cycles after that edge. A run that finds no exponent finishes after 9 cycles. A run that fails the offset check finishes x + 14 cycles after the edge, like a successful one. For every request the bench works out x and the outcome from the arithmetic rules, and from them the finishing cycle. It samples on falling edges and requires `done_o` to be low, with `busy_o` high, on every earlier cycle. It checks all fields on the cycle `done_o` is due. On the next cycle it confirms that `done_o` has dropped, `busy_o` is low and the fields are held. A start pulse injected in the middle of a run must leave that run's result and timing unchanged.

// File: rtl/osc_calc_pkg.sv
package osc_calc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SEARCH = 2'd1,
      ST_SCAN   = 2'd2
   } calc_state_e;
endpackage

// File: rtl/osc_prescale_step.sv
// Scales the request by 2^x, tests the master window and rounds to whole steps.
module osc_prescale_step #(
   parameter int FREQ_W        = 18,
   parameter int FRAC_W        = 4,
   parameter int X_MAX         = 8,
   parameter int WIN_LO        = 6600,
   parameter int WIN_HI        = 13300,
   parameter int MI_W          = 14,
   parameter int ROUND_NEAREST = 1,
   localparam int XW           = $clog2(X_MAX + 1)
) (
   input  logic [FREQ_W-1:0] desired_i,
   input  logic [XW-1:0]     exp_i,
   output logic              legal_o,
   output logic [MI_W-1:0]   master_o
);
   localparam int MFX_W = FREQ_W + X_MAX + 1;
   localparam logic [MFX_W-1:0] LO_FX = MFX_W'(WIN_LO) << FRAC_W;
   localparam logic [MFX_W-1:0] HI_FX = MFX_W'(WIN_HI) << FRAC_W;

   logic [MFX_W-1:0] master_fx;
   logic [MFX_W-1:0] rounded_fx;

   assign master_fx = MFX_W'(desired_i) << exp_i;
   assign legal_o   = (master_fx >= LO_FX) && (master_fx <= HI_FX);

   generate
      if (ROUND_NEAREST != 0 && FRAC_W > 0) begin : g_round_near
         localparam logic [MFX_W-1:0] HALF = MFX_W'(1) << (FRAC_W - 1);
         assign rounded_fx = master_fx + HALF;
      end else begin : g_round_trunc
         assign rounded_fx = master_fx;
      end
   endgenerate

   assign master_o = MI_W'(rounded_fx >> FRAC_W);
endmodule

// File: rtl/osc_range_scan.sv
// Walks the relative offset ranges one per cycle and keeps the best-centred one.
module osc_range_scan #(
   parameter int NUM_RANGES = 13,
   parameter int BASE_MIN   = 6144,
   parameter int RANGE_STEP = 512,
   parameter int SPAN       = 1023,
   parameter int MI_W       = 14,
   localparam int IW        = $clog2(NUM_RANGES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear_i,
   input  logic            step_i,
   input  logic [MI_W-1:0] master_i,
   output logic            last_o,
   output logic            sel_valid_o,
   output logic [IW-1:0]   sel_idx_o
);
   localparam int DW = MI_W + 3;

   logic [IW-1:0]        idx_q;
   logic                 best_valid_q;
   logic [IW-1:0]        best_idx_q;
   logic [DW-1:0]        best_dist_q;
   logic [DW-1:0]        lo_v, hi_v, m_v, dist_v;
   logic signed [DW-1:0] diff_v;
   logic                 covers, take;

   assign lo_v   = DW'(BASE_MIN) + DW'(idx_q) * DW'(RANGE_STEP);
   assign hi_v   = lo_v + DW'(SPAN);
   assign m_v    = DW'(master_i);
   assign covers = (m_v >= lo_v) && (m_v <= hi_v);
   // twice the distance to the centre, always odd when SPAN is odd
   assign diff_v = signed'((m_v << 1) - (lo_v << 1) - DW'(SPAN));
   assign dist_v = diff_v[DW-1] ? DW'(-diff_v) : DW'(diff_v);
   assign take   = covers && (!best_valid_q || (dist_v < best_dist_q));

   assign last_o      = (idx_q == IW'(NUM_RANGES - 1));
   assign sel_valid_o = best_valid_q || (step_i && take);
   assign sel_idx_o   = (step_i && take) ? idx_q : best_idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q        <= '0;
         best_valid_q <= 1'b0;
         best_idx_q   <= '0;
         best_dist_q  <= '0;
      end else if (clear_i) begin
         idx_q        <= '0;
         best_valid_q <= 1'b0;
         best_idx_q   <= '0;
         best_dist_q  <= '0;
      end else if (step_i) begin
         idx_q <= last_o ? '0 : idx_q + IW'(1);
         if (take) begin
            best_valid_q <= 1'b1;
            best_idx_q   <= idx_q;
            best_dist_q  <= dist_v;
         end
      end
   end
endmodule

// File: rtl/osc_result_format.sv
// Forms offset, DAC word, achieved frequency and error from the chosen range.
module osc_result_format #(
   parameter int FREQ_W     = 18,
   parameter int FRAC_W     = 4,
   parameter int X_MAX      = 8,
   parameter int MI_W       = 14,
   parameter int NUM_RANGES = 13,
   parameter int BASE_MIN   = 6144,
   parameter int RANGE_STEP = 512,
   parameter int K_LOW      = -6,
   parameter int OS_W       = 5,
   parameter int CODE_W     = 10,
   parameter int WORD_W     = 16,
   localparam int XW        = $clog2(X_MAX + 1),
   localparam int IW        = $clog2(NUM_RANGES),
   localparam int EW        = MI_W + FRAC_W,
   localparam int ERR_W     = ((EW > FREQ_W) ? EW : FREQ_W) + 1
) (
   input  logic [FREQ_W-1:0]       desired_i,
   input  logic [OS_W-1:0]         factory_os_i,
   input  logic [XW-1:0]           exp_i,
   input  logic [MI_W-1:0]         master_i,
   input  logic [IW-1:0]           sel_idx_i,
   output logic [WORD_W-1:0]       dac_word_o,
   output logic [OS_W-1:0]         offset_o,
   output logic                    offset_bad_o,
   output logic [EW-1:0]           expected_o,
   output logic signed [ERR_W-1:0] freq_err_o
);
   localparam int OW = OS_W + 2;
   localparam logic signed [OW-1:0] KL = OW'(K_LOW);

   logic [MI_W-1:0]      lo_v;
   logic [CODE_W-1:0]    code_v;
   logic signed [OW-1:0] sum_v;
   logic [EW-1:0]        scaled_v;

   assign lo_v       = MI_W'(BASE_MIN) + MI_W'(sel_idx_i) * MI_W'(RANGE_STEP);
   assign code_v     = CODE_W'(master_i - lo_v);
   assign dac_word_o = WORD_W'(code_v) << (WORD_W - CODE_W);

   assign sum_v        = $signed(OW'(factory_os_i)) + $signed(OW'(sel_idx_i)) + KL;
   assign offset_bad_o = sum_v[OW-1] || (sum_v[OW-2:OS_W] != '0);
   assign offset_o     = sum_v[OS_W-1:0];

   assign scaled_v   = {master_i, {FRAC_W{1'b0}}};
   assign expected_o = scaled_v >> exp_i;
   assign freq_err_o = $signed(ERR_W'(expected_o)) - $signed(ERR_W'(desired_i));
endmodule

// File: rtl/osc_calc_top.sv
module osc_calc_top #(
   parameter int FREQ_W        = 18,
   parameter int FRAC_W        = 4,
   parameter int X_MAX         = 8,
   parameter int WIN_LO        = 6600,
   parameter int WIN_HI        = 13300,
   parameter int NUM_RANGES    = 13,
   parameter int BASE_MIN      = 6144,
   parameter int RANGE_STEP    = 512,
   parameter int SPAN          = 1023,
   parameter int K_LOW         = -6,
   parameter int OS_W          = 5,
   parameter int CODE_W        = 10,
   parameter int WORD_W        = 16,
   parameter int ROUND_NEAREST = 1,
   localparam int XW           = $clog2(X_MAX + 1),
   localparam int MI_W         = $clog2(WIN_HI + 2),
   localparam int EW           = MI_W + FRAC_W,
   localparam int ERR_W        = ((EW > FREQ_W) ? EW : FREQ_W) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_i,
   input  logic [FREQ_W-1:0]       desired_i,
   input  logic [OS_W-1:0]         factory_os_i,
   output logic                    busy_o,
   output logic                    done_o,
   output logic                    err_o,
   output logic [XW-1:0]           prescale_exp_o,
   output logic [OS_W-1:0]         offset_o,
   output logic [WORD_W-1:0]       dac_word_o,
   output logic [EW-1:0]           expected_o,
   output logic signed [ERR_W-1:0] freq_err_o
);
   import osc_calc_pkg::*;

   localparam int IW = $clog2(NUM_RANGES);

   generate
      if (WIN_LO >= WIN_HI) begin : g_bad_window
         $error("osc_calc_top: master window is empty");
      end
      if (NUM_RANGES < 2) begin : g_bad_ranges
         $error("osc_calc_top: at least two offset ranges required");
      end
      if (WORD_W < CODE_W || SPAN >= (1 << CODE_W)) begin : g_bad_code
         $error("osc_calc_top: DAC code does not fit its word");
      end
      if (BASE_MIN + (NUM_RANGES - 1) * RANGE_STEP >= (1 << MI_W)) begin : g_bad_base
         $error("osc_calc_top: range minimum exceeds master width");
      end
   endgenerate

   calc_state_e             state_q;
   logic [FREQ_W-1:0]       desired_q;
   logic [OS_W-1:0]         os_q;
   logic [XW-1:0]           exp_q;
   logic                    done_q, err_q;
   logic [XW-1:0]           exp_out_q;
   logic [OS_W-1:0]         offset_q;
   logic [WORD_W-1:0]       word_q;
   logic [EW-1:0]           expected_q;
   logic signed [ERR_W-1:0] ferr_q;

   logic                    legal;
   logic [MI_W-1:0]         master;
   logic                    scan_last, sel_valid;
   logic [IW-1:0]           sel_idx;
   logic [WORD_W-1:0]       word_c;
   logic [OS_W-1:0]         offset_c;
   logic                    offset_bad;
   logic [EW-1:0]           expected_c;
   logic signed [ERR_W-1:0] ferr_c;

   osc_prescale_step #(
      .FREQ_W(FREQ_W), .FRAC_W(FRAC_W), .X_MAX(X_MAX), .WIN_LO(WIN_LO),
      .WIN_HI(WIN_HI), .MI_W(MI_W), .ROUND_NEAREST(ROUND_NEAREST)
   ) u_step (
      .desired_i(desired_q), .exp_i(exp_q), .legal_o(legal), .master_o(master)
   );

   osc_range_scan #(
      .NUM_RANGES(NUM_RANGES), .BASE_MIN(BASE_MIN), .RANGE_STEP(RANGE_STEP),
      .SPAN(SPAN), .MI_W(MI_W)
   ) u_scan (
      .clk(clk), .rst_n(rst_n),
      .clear_i(state_q != ST_SCAN), .step_i(state_q == ST_SCAN),
      .master_i(master), .last_o(scan_last),
      .sel_valid_o(sel_valid), .sel_idx_o(sel_idx)
   );

   osc_result_format #(
      .FREQ_W(FREQ_W), .FRAC_W(FRAC_W), .X_MAX(X_MAX), .MI_W(MI_W),
      .NUM_RANGES(NUM_RANGES), .BASE_MIN(BASE_MIN), .RANGE_STEP(RANGE_STEP),
      .K_LOW(K_LOW), .OS_W(OS_W), .CODE_W(CODE_W), .WORD_W(WORD_W)
   ) u_fmt (
      .desired_i(desired_q), .factory_os_i(os_q), .exp_i(exp_q),
      .master_i(master), .sel_idx_i(sel_idx),
      .dac_word_o(word_c), .offset_o(offset_c), .offset_bad_o(offset_bad),
      .expected_o(expected_c), .freq_err_o(ferr_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         desired_q  <= '0;
         os_q       <= '0;
         exp_q      <= '0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         exp_out_q  <= '0;
         offset_q   <= '0;
         word_q     <= '0;
         expected_q <= '0;
         ferr_q     <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  desired_q <= desired_i;
                  os_q      <= factory_os_i;
                  exp_q     <= '0;
                  state_q   <= ST_SEARCH;
               end
            end
            ST_SEARCH: begin
               if (legal) begin
                  state_q <= ST_SCAN;
               end else if (exp_q == XW'(X_MAX)) begin
                  state_q    <= ST_IDLE;
                  done_q     <= 1'b1;
                  err_q      <= 1'b1;
                  exp_out_q  <= '0;
                  offset_q   <= '0;
                  word_q     <= '0;
                  expected_q <= '0;
                  ferr_q     <= '0;
               end else begin
                  exp_q <= exp_q + XW'(1);
               end
            end
            ST_SCAN: begin
               if (scan_last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  if (!sel_valid || offset_bad) begin
                     err_q      <= 1'b1;
                     exp_out_q  <= '0;
                     offset_q   <= '0;
                     word_q     <= '0;
                     expected_q <= '0;
                     ferr_q     <= '0;
                  end else begin
                     err_q      <= 1'b0;
                     exp_out_q  <= exp_q;
                     offset_q   <= offset_c;
                     word_q     <= word_c;
                     expected_q <= expected_c;
                     ferr_q     <= ferr_c;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o         = (state_q != ST_IDLE);
   assign done_o         = done_q;
   assign err_o          = err_q;
   assign prescale_exp_o = exp_out_q;
   assign offset_o       = offset_q;
   assign dac_word_o     = word_q;
   assign expected_o     = expected_q;
   assign freq_err_o     = ferr_q;
endmodule

// File: rtl/osc_calc_chk.sv
module osc_calc_chk #(
   parameter int X_MAX  = 8,
   parameter int XW     = 4,
   parameter int OS_W   = 5,
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic [XW-1:0]     prescale_exp_o,
   input logic [OS_W-1:0]   offset_o,
   input logic [WORD_W-1:0] dac_word_o
);
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(dac_word_o) && $stable(offset_o) &&
                   $stable(prescale_exp_o) && $stable(err_o)));

   a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));

   a_r2_exp_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (prescale_exp_o <= XW'(X_MAX)));

   a_r3_err_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (dac_word_o == '0 && offset_o == '0 && prescale_exp_o == '0));
endmodule

bind osc_calc_top osc_calc_chk #(
   .X_MAX(X_MAX), .XW(XW), .OS_W(OS_W), .WORD_W(WORD_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .err_o(err_o), .prescale_exp_o(prescale_exp_o),
   .offset_o(offset_o), .dac_word_o(dac_word_o)
);

// File: tb/osc_calc_top_tb_top.sv
`timescale 1ns/1ps
module osc_calc_top_tb_top;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [17:0]       desired = '0;
   logic [4:0]        fos = '0;
   logic              busy, done, err;
   logic [3:0]        xexp;
   logic [4:0]        offset;
   logic [15:0]       word;
   logic [17:0]       expected;
   logic signed [18:0] ferr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   osc_calc_top dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .desired_i(desired),
      .factory_os_i(fos), .busy_o(busy), .done_o(done), .err_o(err),
      .prescale_exp_o(xexp), .offset_o(offset), .dac_word_o(word),
      .expected_o(expected), .freq_err_o(ferr)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
         finish_run();
      end
   end

   // Arithmetic model of the requirements.
   task automatic model(input int d, input int os, output bit rfail, output int rx,
                        output int roff, output int rword, output int rexp,
                        output int rerr, output int rlat);
      bit found = 0;
      int m, best_k, best_d;
      rfail = 0; rx = 0; roff = 0; rword = 0; rexp = 0; rerr = 0;
      for (int x = 0; x <= 8; x++) begin
         if (!found && d * (1 << x) >= 6600 * 16 && d * (1 << x) <= 13300 * 16) begin
            found = 1;
            rx = x;
         end
      end
      if (!found) begin
         rfail = 1; rlat = 9;
         return;
      end
      rlat = rx + 14;
      m = (d * (1 << rx) + 8) / 16;
      best_d = 1 << 30;
      best_k = 99;
      for (int k = -6; k <= 6; k++) begin
         int lo, dd;
         lo = 9216 + 512 * k;
         dd = 2 * m - 2 * lo - 1023;
         if (dd < 0) dd = -dd;
         if (m >= lo && m <= lo + 1023 && dd < best_d) begin
            best_d = dd;
            best_k = k;
         end
      end
      if (best_k == 99 || os + best_k < 0 || os + best_k > 31) begin
         rfail = 1; rx = 0;
         return;
      end
      roff  = os + best_k;
      rword = (m - (9216 + 512 * best_k)) * 64;
      rexp  = (m * 16) >> rx;
      rerr  = rexp - d;
   endtask

   task automatic run_one(input int d, input int os, input bit intrude);
      bit rfail, early;
      int rx, roff, rword, rexp, rerr, rlat;
      int h_word, h_off, h_x;
      model(d, os, rfail, rx, roff, rword, rexp, rerr, rlat);
      @(negedge clk);
      start = 1'b1; desired = 18'(d); fos = 5'(os);
      @(negedge clk);
      start = 1'b0;
      early = 0;
      for (int n = 1; n <= rlat; n++) begin
         @(negedge clk);
         if (intrude && n == 2) begin
            start = 1'b1; desired = 18'(d ^ 18'h15a5a); fos = 5'(os ^ 3);
         end
         if (intrude && n == 3) start = 1'b0;
         if (n < rlat && (done || !busy)) early = 1;
      end
      check(!early, "R8", "done early or busy low before due cycle", early, 0);
      check(done == 1'b1, "R8", "done on due cycle", done, 1);
      check(busy == 1'b0, "R8", "busy low at done", busy, 0);
      check(err == rfail, rfail ? "R3" : "R6", "err flag", err, rfail);
      check(int'(xexp) == rx, "R2", "exponent", xexp, rx);
      check(int'(offset) == roff, "R6", "offset", offset, roff);
      check(int'(word) == rword, "R5", "dac word", word, rword);
      check(int'(expected) == rexp, "R7", "expected freq", expected, rexp);
      check(int'(ferr) == rerr, "R7", "freq error", ferr, rerr);
      if (intrude)
         check(!early && int'(word) == rword, "R10", "intruding start ignored", word, rword);
      h_word = word; h_off = offset; h_x = xexp;
      @(negedge clk);
      check(done == 1'b0, "R9", "done one cycle", done, 0);
      check(int'(word) == h_word && int'(offset) == h_off && int'(xexp) == h_x,
            "R9", "fields held", word, h_word);
      check(busy == 1'b0, "R10", "no queued run", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!done && !err && !busy, "R1", "flags in reset", {done, err, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!done && !err && !busy && word == 0 && offset == 0 && xexp == 0 &&
            expected == 0 && ferr == 0, "R1", "state after reset", word, 0);

      // 100 MHz, factory offset 12h: x=0, offset 13h, word 4400h (R4, R5)
      run_one(160000, 18, 0);
      check(word == 16'h4400 && offset == 5'h13, "R5", "100 MHz example word", word, 16'h4400);
      // 11.0594 MHz: x=3, range -2, offset 10h (R4)
      run_one(17695, 18, 0);
      check(offset == 5'h10 && xexp == 3, "R4", "range -2 chosen", offset, 5'h10);
      // rounding half up vs down (R4)
      run_one(105608, 10, 0);
      check(int'(word) == (6601 - 6144) * 64, "R4", "round half up", word, (6601 - 6144) * 64);
      run_one(105607, 10, 0);
      check(int'(word) == (6600 - 6144) * 64, "R4", "round below half", word, (6600 - 6144) * 64);
      // window edges (R2, R3)
      run_one(105600, 10, 0);
      run_one(105599, 10, 0);
      run_one(212800, 10, 0);
      run_one(212801, 10, 0);
      run_one(0, 10, 0);
      run_one(400, 10, 0);
      run_one(416, 10, 0);
      // offset limits (R6)
      run_one(107200, 0, 0);
      run_one(107200, 6, 0);
      run_one(208000, 31, 0);
      run_one(208000, 25, 0);
      // start during a run (R10)
      run_one(160000, 18, 1);
      run_one(3000, 7, 1);
      // sweep across the input range
      for (int i = 0; i < 1010; i++) begin
         run_one(i * 211 + (i % 13), (i * 7) % 32, 0);
      end
      finish_run();
   end
endmodule